// File: doc/BRIEF.md
# Scalable Fixed-Point Multiplier Coprocessor

This block multiplies two 32-bit operands and returns a result that is already scaled for a chosen fixed-point format. A 6-bit control word travels with each command. The low five bits give a right shift, from 0 to 31, which is applied to the 64-bit product. The top bit chooses two's-complement or unsigned arithmetic. The unit returns two words. The first is the 32-bit slice of the product that starts at the chosen shift. The second is always the upper half of the unshifted product.

A 16.16 by 16.16 multiply therefore takes a shift of 16. An 8.24 signed multiply takes the signed bit and a shift of 24. A plain integer multiply takes a shift of zero. Commands enter through a valid/ready port, and results leave through a valid/ready port. The unit is a three-register pipeline. The whole pipeline freezes when a result waits for a consumer that is not ready.

Top module: `fxmul_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_valid` is 0 after that edge, and `cmd_ready` is 1 for as long as no result is pending.
- R2: When `cmd_ctrl[5]` is 0, `res_lo` equals bits [31+s:s] of the unsigned 64-bit product of `cmd_a` and `cmd_b`, where s is `cmd_ctrl[4:0]`.
- R3: When `cmd_ctrl[5]` is 1, the operands are two's-complement numbers, and `res_lo` equals bits [31+s:s] of their signed 64-bit product.
- R4: `res_hi` equals bits [63:32] of the product in the selected mode, whatever the shift.
- R5: Fixed examples hold. Unsigned with s=0 gives the integer product bits [31:0]. With s=16, 0x00018000 times 0x00024000 gives 0x00036000. Signed with s=24, 0xFE800000 times 0x02000000 gives 0xFD000000.
- R6: With s=0, the signed and unsigned modes give the same `res_lo` for the same operands.
- R7: With `res_ready` held high, a command accepted at a clock edge shows `res_valid` high after the third edge, counting the accepting edge as the first. `res_valid` is low after the first and after the second of those edges.
- R8: While `res_ready` stays high, `cmd_ready` stays high, and one command is accepted on every edge.
- R9: While `res_valid` is 1 and `res_ready` is 0, `cmd_ready` is 0. On the next edge `res_valid`, `res_lo` and `res_hi` keep their values.
- R10: Every accepted command produces exactly one result. Results leave in the order their commands were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_a | input | 32 | First operand |
| cmd_b | input | 32 | Second operand |
| cmd_ctrl | input | 6 | Bit 5: signed mode; bits [4:0]: right shift |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_valid | output | 1 | Result present |
| res_lo | output | 32 | Shifted 32-bit slice of the product |
| res_hi | output | 32 | Bits [63:32] of the unshifted product |

## Verification
Two events can fall in the same cycle: a consumer stall on the result side and a new command at the input. While the pipeline is frozen, the stall must both refuse the command and hold the output. A scoreboard run drives commands back to back while a pseudo-random pattern drops `res_ready`. In every stalled cycle the run checks that `cmd_ready` is low and that the held result does not change. Because the queue compares results in order, any command that is lost or duplicated around a stall shows up as a mismatch.

// File: rtl/fxmul_pkg.sv
// Shared definitions for the fixed-point multiplier.
// Assumes: the control word is {mode bit, shift field}.
package fxmul_pkg;

    // Arithmetic interpretation of the operands.
    typedef enum logic {
        FX_UNSIGNED = 1'b0,
        FX_SIGNED   = 1'b1
    } fx_mode_e;

    // Split a control word of width CW into its mode bit (the MSB).
    function automatic fx_mode_e fx_mode_of(input logic msb);
        return msb ? FX_SIGNED : FX_UNSIGNED;
    endfunction

endpackage

// File: rtl/fxmul_opnd_stage.sv
// Stage 1: captures the operands, the mode and the shift of an accepted command.
// Assumes: adv is the common pipeline advance. Only the valid flag is reset.
module fxmul_opnd_stage
    import fxmul_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SHW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           in_v,
    input  logic [DW-1:0]  in_a,
    input  logic [DW-1:0]  in_b,
    input  logic           in_msb,
    input  logic [SHW-1:0] in_sh,
    output logic           out_v,
    output logic [DW-1:0]  out_a,
    output logic [DW-1:0]  out_b,
    output fx_mode_e       out_mode,
    output logic [SHW-1:0] out_sh
);

    // Valid flag: cleared by reset, moves only on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_v <= 1'b0;
        else if (adv) out_v <= in_v;
    end

    // Data capture: loads only when a command is taken.
    always_ff @(posedge clk) begin
        if (adv && in_v) begin
            out_a    <= in_a;
            out_b    <= in_b;
            out_mode <= fx_mode_of(in_msb);
            out_sh   <= in_sh;
        end
    end

endmodule

// File: rtl/fxmul_prod_stage.sv
// Stage 2: forms the full 2*DW-bit product in the selected mode.
// Assumes: in signed mode the operands are sign-extended by one bit, and in unsigned mode they are zero-extended.
module fxmul_prod_stage
    import fxmul_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SHW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            in_v,
    input  logic [DW-1:0]   in_a,
    input  logic [DW-1:0]   in_b,
    input  fx_mode_e        in_mode,
    input  logic [SHW-1:0]  in_sh,
    output logic            out_v,
    output logic [2*DW-1:0] out_prod,
    output logic [SHW-1:0]  out_sh
);

    localparam int PW = 2 * DW;

    logic signed [DW:0]   ext_a;
    logic signed [DW:0]   ext_b;
    logic        [PW-1:0] prod_d;

    // Operand extension and multiply: the extension bit selects the arithmetic.
    always_comb begin
        ext_a  = {(in_mode == FX_SIGNED) & in_a[DW-1], in_a};
        ext_b  = {(in_mode == FX_SIGNED) & in_b[DW-1], in_b};
        prod_d = PW'(ext_a * ext_b);
    end

    // Valid flag: cleared by reset, moves only on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_v <= 1'b0;
        else if (adv) out_v <= in_v;
    end

    // Product register.
    always_ff @(posedge clk) begin
        if (adv && in_v) begin
            out_prod <= prod_d;
            out_sh   <= in_sh;
        end
    end

endmodule

// File: rtl/fxmul_win_stage.sv
// Stage 3: takes a DW-bit slice of the product at the requested shift and keeps the raw upper half.
// Assumes: the shift stays below DW, so the slice never reaches above the product MSB.
module fxmul_win_stage #(
    parameter int DW  = 32,
    parameter int SHW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            in_v,
    input  logic [2*DW-1:0] in_prod,
    input  logic [SHW-1:0]  in_sh,
    output logic            out_v,
    output logic [DW-1:0]   out_lo,
    output logic [DW-1:0]   out_hi
);

    logic [DW-1:0] slice_d;

    // Barrel slice: logical right shift, then truncate to DW bits.
    always_comb slice_d = DW'(in_prod >> in_sh);

    // Valid flag: cleared by reset, moves only on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_v <= 1'b0;
        else if (adv) out_v <= in_v;
    end

    // Result registers.
    always_ff @(posedge clk) begin
        if (adv && in_v) begin
            out_lo <= slice_d;
            out_hi <= in_prod[2*DW-1:DW];
        end
    end

endmodule

// File: rtl/fxmul_unit.sv
// Fixed-point multiplier: a three-stage pipeline with one shared advance signal.
// Assumes: a pending result that is not taken freezes every stage, and the input port is then closed.
module fxmul_unit
    import fxmul_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SHW = $clog2(DW),
    parameter int CW  = SHW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [DW-1:0] cmd_a,
    input  logic [DW-1:0] cmd_b,
    input  logic [CW-1:0] cmd_ctrl,
    input  logic          res_ready,
    output logic          res_valid,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi
);

    logic            adv;
    logic            s1_v, s2_v;
    logic [DW-1:0]   s1_a, s1_b;
    fx_mode_e        s1_mode;
    logic [SHW-1:0]  s1_sh, s2_sh;
    logic [2*DW-1:0] s2_prod;

    // Global advance: move unless the output holds an untaken result.
    always_comb adv = !res_valid || res_ready;
    assign cmd_ready = adv;

    fxmul_opnd_stage #(.DW(DW), .SHW(SHW)) u_opnd (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .in_v(cmd_valid), .in_a(cmd_a), .in_b(cmd_b),
        .in_msb(cmd_ctrl[CW-1]), .in_sh(cmd_ctrl[SHW-1:0]),
        .out_v(s1_v), .out_a(s1_a), .out_b(s1_b),
        .out_mode(s1_mode), .out_sh(s1_sh)
    );

    fxmul_prod_stage #(.DW(DW), .SHW(SHW)) u_prod (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .in_v(s1_v), .in_a(s1_a), .in_b(s1_b),
        .in_mode(s1_mode), .in_sh(s1_sh),
        .out_v(s2_v), .out_prod(s2_prod), .out_sh(s2_sh)
    );

    fxmul_win_stage #(.DW(DW), .SHW(SHW)) u_win (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .in_v(s2_v), .in_prod(s2_prod), .in_sh(s2_sh),
        .out_v(res_valid), .out_lo(res_lo), .out_hi(res_hi)
    );

endmodule

// File: rtl/fxmul_unit_chk.sv
// Protocol checker for fxmul_unit, attached by bind.
// Assumes: a handshake fires on an edge where valid and ready are both high.
module fxmul_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          res_ready,
    input logic          res_valid,
    input logic [DW-1:0] res_lo,
    input logic [DW-1:0] res_hi
);

    logic [2:0] inflight;

    // Count commands accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else inflight <= inflight + 3'(cmd_valid && cmd_ready) - 3'(res_valid && res_ready);
    end

    // R1: reset empties the output.
    p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> !res_valid);

    // R9: a stalled result holds its value.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_lo) && $stable(res_hi)));

    // R9: a stalled result closes the input.
    p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> !cmd_ready);

    // R10: no more than three commands are ever in flight.
    p_inflight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 3'd3);

    // R10: a result appears only if a command is outstanding.
    p_no_phantom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> inflight != 3'd0);

endmodule

bind fxmul_unit fxmul_unit_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .res_ready(res_ready), .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi)
);

// File: tb/test_fxmul_unit.sv
// Scoreboard bench for fxmul_unit: the driver queues expected items, the monitor pops and compares them.
module test_fxmul_unit;

    typedef struct {
        logic [31:0] a, b;
        logic [5:0]  c;
        logic [31:0] lo, hi, ulo;
        bit          lit_en;
        logic [31:0] lit;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [31:0] cmd_a = 0, cmd_b = 0;
    logic [5:0]  cmd_ctrl = 0;
    logic        res_ready = 1;
    logic        res_valid;
    logic [31:0] res_lo, res_hi;

    item_t q[$];
    int n_cmp = 0, n_bad = 0, n_sent = 0, n_got = 0;
    bit stall_mode = 0;
    logic [15:0] rl = 16'hACE1;

    fxmul_unit i_fxmul_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_ctrl(cmd_ctrl),
        .res_ready(res_ready), .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Reference product from the requirements.
    function automatic logic [63:0] ref_prod(input logic [31:0] a, b, input bit sgn);
        logic [63:0] ea, eb;
        ea = sgn ? {{32{a[31]}}, a} : {32'b0, a};
        eb = sgn ? {{32{b[31]}}, b} : {32'b0, b};
        return ea * eb;
    endfunction

    task automatic send(input logic [31:0] a, b, input logic [5:0] c,
                        input bit lit_en, input logic [31:0] lit, output int waits);
        item_t it;
        logic [63:0] p;
        waits = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_a = a; cmd_b = b; cmd_ctrl = c;
        #1;
        while (!cmd_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        p = ref_prod(a, b, c[5]);
        it.a = a; it.b = b; it.c = c;
        it.lo = 32'(p >> c[4:0]);
        it.hi = p[63:32];
        it.ulo = 32'(ref_prod(a, b, 1'b0));
        it.lit_en = lit_en; it.lit = lit;
        q.push_back(it);
        n_sent++;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_valid = 0;
    endtask

    // Consumer ready pattern.
    always @(negedge clk) begin
        rl = {rl[14:0], rl[15] ^ rl[13] ^ rl[12] ^ rl[10]};
        res_ready = stall_mode ? (rl[0] | rl[5]) : 1'b1;
    end

    // Monitor: samples between edges, compares and checks stall behaviour.
    initial begin
        bit prev_stall = 0;
        logic [31:0] plo = 0, phi = 0;
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (prev_stall) begin
                    check(res_valid === 1'b1, "R9 valid held", {31'b0, res_valid}, 32'd1);
                    check(res_lo === plo, "R9 lo held", res_lo, plo);
                    check(res_hi === phi, "R9 hi held", res_hi, phi);
                end
                if (res_valid && !res_ready)
                    check(cmd_ready === 1'b0, "R9 input closed", {31'b0, cmd_ready}, 32'd0);
                if (res_valid && res_ready) begin
                    if (q.size() == 0) begin
                        check(0, "R10 unexpected result", res_lo, 32'hx);
                    end else begin
                        it = q.pop_front();
                        n_got++;
                        check(res_lo === it.lo, it.c[5] ? "R3 signed slice" : "R2 unsigned slice", res_lo, it.lo);
                        check(res_hi === it.hi, "R4 upper half", res_hi, it.hi);
                        if (it.c == 6'd32)
                            check(res_lo === it.ulo, "R6 low half mode-independent", res_lo, it.ulo);
                        if (it.lit_en)
                            check(res_lo === it.lit, "R5 fixed example", res_lo, it.lit);
                    end
                end
                prev_stall = res_valid && !res_ready;
                plo = res_lo; phi = res_hi;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int w, tot;
        logic [31:0] la, lb;
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check(res_valid === 1'b0, "R1 reset valid", {31'b0, res_valid}, 32'd0);
        check(cmd_ready === 1'b1, "R1 reset ready", {31'b0, cmd_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1;

        // R5: fixed examples
        send(32'h12345678, 32'h9ABCDEF0, 6'd0, 1, 32'h12345678 * 32'h9ABCDEF0, w);
        send(32'h00018000, 32'h00024000, 6'd16, 1, 32'h00036000, w);
        send(32'hFE800000, 32'h02000000, 6'd56, 1, 32'hFD000000, w);
        // R6: same operands, both modes at shift 0
        send(32'hFFFF1234, 32'h80000003, 6'd0, 0, 0, w);
        send(32'hFFFF1234, 32'h80000003, 6'd32, 0, 0, w);
        idle();
        repeat (6) @(negedge clk);

        // R7: latency with the consumer always ready
        send(32'd7, 32'd9, 6'd0, 0, 0, w);
        @(negedge clk); cmd_valid = 0; #3;
        check(res_valid === 1'b0, "R7 not valid after edge 1", {31'b0, res_valid}, 32'd0);
        @(negedge clk); #3;
        check(res_valid === 1'b0, "R7 not valid after edge 2", {31'b0, res_valid}, 32'd0);
        @(negedge clk); #3;
        check(res_valid === 1'b1, "R7 valid after edge 3", {31'b0, res_valid}, 32'd1);
        repeat (3) @(negedge clk);

        // R8: back-to-back throughput
        tot = 0;
        for (int i = 0; i < 8; i++) begin
            send(32'h01000000 * i + 32'h55, 32'hF0F0F0F0 - i, 6'(i * 9), 0, 0, w);
            tot += w;
        end
        idle();
        check(tot == 0, "R8 no wait cycles", tot, 0);
        repeat (6) @(negedge clk);

        // R2/R3/R4/R9/R10: random traffic under consumer stalls
        stall_mode = 1;
        la = 32'h1234ABCD; lb = 32'h8F00_0F01;
        for (int i = 0; i < 300; i++) begin
            la = la * 32'd1664525 + 32'd1013904223;
            lb = lb * 32'd22695477 + 32'd1;
            send(la, lb ^ (la >> 7), la[13:8], 0, 0, w);
        end
        idle();
        stall_mode = 0;
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(n_got == n_sent, "R10 one result per command", n_got, n_sent);
        check(res_valid === 1'b0, "R10 nothing extra", {31'b0, res_valid}, 32'd0);
        finish_run();
    end

endmodule